// File: doc/BRIEF.md
# Thermal Fan Step and Shutdown Controller

This block turns two temperature readings into fan and protection outputs. One reading comes from a sensor in the power supply and the other from a sensor on the processor. Each reading is an 8-bit signed whole number of degrees Celsius and comes with a one-cycle valid strobe. The power-supply reading alone sets one speed command, which two variable-speed fans share. The command has three levels and uses hysteresis on the way down. A third fan's enable stays on at all times. When the fans reach their top level, a warning tells the user that a shutdown may come soon.

Either sensor can ask for a shutdown when it passes its own critical limit. The shutdown request and a cause bit for each sensor are latched and stay set until reset. Supervisory logic reads these bits to power the system down and to show which sensor tripped. All outputs are registered. They change on the clock edge that samples a valid reading.

Top module: `thermal_fan_ctrl`

## Requirements
- R1: After reset, fanSpeed is 0 (low), and nearShutdownWarn, shutdownReq, supplyFault and cpuFault are all 0. auxFanOn is 1 at all times, reset included.
- R2: The fanSpeed code is 0 for low, 1 for medium and 2 for high. At low, a valid supply reading above 39 moves the speed to medium. A reading of exactly 39 leaves it at low.
- R3: A valid supply reading above 51 sets fanSpeed to 2 from any level. The code 3 never appears. nearShutdownWarn is 1 exactly when fanSpeed is 2.
- R4: Hysteresis of 2 degrees applies on the way down. High holds while readings are 49 or more, and drops to medium for readings from 37 to 48. Medium holds while readings are 37 or more. Any reading below 37 gives low.
- R5: Processor readings never change fanSpeed.
- R6: A reading whose valid strobe is low changes no output.
- R7: A valid supply reading above 97 sets supplyFault and shutdownReq. A reading of exactly 97 sets neither.
- R8: A valid processor reading above 100 sets cpuFault and shutdownReq. A reading of exactly 100 sets neither.
- R9: shutdownReq and the two cause bits stay set until rstN is low. If both limits trip in the same cycle, both cause bits are set.
- R10: Readings are two's complement. A negative value (for example 0x9C, which is -100) counts as cold and never trips or raises the speed.
- R11: Each output reflects a valid reading one clock edge after the reading is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supplyTemp | input | 8 | Power-supply temperature, signed °C |
| supplyValid | input | 1 | supplyTemp is valid this cycle |
| cpuTemp | input | 8 | Processor temperature, signed °C |
| cpuValid | input | 1 | cpuTemp is valid this cycle |
| fanSpeed | output | 2 | Shared speed command for the variable fans (0 low, 1 medium, 2 high) |
| auxFanOn | output | 1 | Enable for the fixed-speed fan |
| nearShutdownWarn | output | 1 | Fans at maximum; a shutdown may follow |
| shutdownReq | output | 1 | Latched shutdown request |
| supplyFault | output | 1 | Latched: the supply limit caused a shutdown |
| cpuFault | output | 1 | Latched: the processor limit caused a shutdown |

## Verification
Two pairs of functions can act on the same clock edge. In the first pair, a supply reading of 98 starts from low speed. That one edge must jump the speed to high, raise the warning and latch the supply cause bit together. The bench expects all three in the same sample and expects cpuFault to stay clear. In the second pair, the bench presents a supply reading of 100 and a processor reading of 120 in the same cycle. After that edge both cause bits and the request must be set. A later cool reading must not clear them; only reset does.

// File: rtl/thermal_fan_pkg.sv
package thermal_fan_pkg;

  typedef enum logic [1:0] {
    SPEED_LOW  = 2'd0,
    SPEED_MED  = 2'd1,
    SPEED_HIGH = 2'd2
  } fanSpeed_e;

  // Comparison results from the datapath
  typedef struct packed {
    logic overMedUp;   // supply above the medium step-up point
    logic holdMed;     // supply at or above the medium step-down point
    logic overHighUp;  // supply above the high step-up point
    logic holdHigh;    // supply at or above the high step-down point
    logic supplyCrit;  // supply above its shutdown limit
    logic cpuCrit;     // processor above its shutdown limit
  } tempFlags_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic      loadSpeed;
    fanSpeed_e nextSpeed;
    logic      tripSupply;
    logic      tripCpu;
  } ctrlStrobes_t;

endpackage

// File: rtl/thermal_fan_datapath.sv
module thermal_fan_datapath
  import thermal_fan_pkg::*;
#(
  parameter int TEMP_W       = 8,
  parameter int MED_UP       = 39,
  parameter int HIGH_UP      = 51,
  parameter int HYST         = 2,
  parameter int SUPPLY_LIMIT = 97,
  parameter int CPU_LIMIT    = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] supplyTemp,
  input  logic [TEMP_W-1:0] cpuTemp,
  input  ctrlStrobes_t      strobes,
  output tempFlags_t        flags,
  output fanSpeed_e         curSpeed,
  output logic              warnOut,
  output logic              shutOut,
  output logic              supplyFaultOut,
  output logic              cpuFaultOut
);

  localparam int MED_DOWN    = MED_UP - HYST;
  localparam int HIGH_DOWN   = HIGH_UP - HYST;
  localparam int NUM_SENSORS = 2;

  int supplyVal;
  int cpuVal;

  always_comb begin
    supplyVal = int'($signed(supplyTemp));
    cpuVal    = int'($signed(cpuTemp));
  end

  always_comb begin
    flags.overMedUp  = supplyVal > MED_UP;
    flags.holdMed    = supplyVal >= MED_DOWN;
    flags.overHighUp = supplyVal > HIGH_UP;
    flags.holdHigh   = supplyVal >= HIGH_DOWN;
    flags.supplyCrit = supplyVal > SUPPLY_LIMIT;
    flags.cpuCrit    = cpuVal > CPU_LIMIT;
  end

  // Speed and warning registers
  fanSpeed_e speedQ;
  logic      warnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      speedQ <= SPEED_LOW;
      warnQ  <= 1'b0;
    end else if (strobes.loadSpeed) begin
      speedQ <= strobes.nextSpeed;
      warnQ  <= (strobes.nextSpeed == SPEED_HIGH);
    end
  end

  // One sticky cause latch per sensor
  logic [NUM_SENSORS-1:0] tripVec;
  logic [NUM_SENSORS-1:0] faultVec;

  assign tripVec = {strobes.tripCpu, strobes.tripSupply};

  for (genvar s = 0; s < NUM_SENSORS; s++) begin : g_cause
    logic causeQ;
    always_ff @(posedge clk) begin
      if (!rstN)           causeQ <= 1'b0;
      else if (tripVec[s]) causeQ <= 1'b1;
    end
    assign faultVec[s] = causeQ;
  end

  logic shutQ;
  always_ff @(posedge clk) begin
    if (!rstN)          shutQ <= 1'b0;
    else if (|tripVec)  shutQ <= 1'b1;
  end

  assign curSpeed       = speedQ;
  assign warnOut        = warnQ;
  assign shutOut        = shutQ;
  assign supplyFaultOut = faultVec[0];
  assign cpuFaultOut    = faultVec[1];

endmodule

// File: rtl/thermal_fan_control.sv
module thermal_fan_control
  import thermal_fan_pkg::*;
(
  input  logic         supplyValid,
  input  logic         cpuValid,
  input  tempFlags_t   flags,
  input  fanSpeed_e    curSpeed,
  output ctrlStrobes_t strobes
);

  fanSpeed_e target;

  always_comb begin
    target = curSpeed;
    if (flags.overHighUp) begin
      target = SPEED_HIGH;
    end else begin
      unique case (curSpeed)
        SPEED_HIGH: target = flags.holdHigh ? SPEED_HIGH
                           : (flags.holdMed ? SPEED_MED : SPEED_LOW);
        SPEED_MED:  target = flags.holdMed ? SPEED_MED : SPEED_LOW;
        default:    target = flags.overMedUp ? SPEED_MED : SPEED_LOW;
      endcase
    end
  end

  always_comb begin
    strobes.loadSpeed  = supplyValid;
    strobes.nextSpeed  = target;
    strobes.tripSupply = supplyValid && flags.supplyCrit;
    strobes.tripCpu    = cpuValid && flags.cpuCrit;
  end

endmodule

// File: rtl/thermal_fan_ctrl.sv
module thermal_fan_ctrl
  import thermal_fan_pkg::*;
#(
  parameter int TEMP_W       = 8,
  parameter int MED_UP       = 39,
  parameter int HIGH_UP      = 51,
  parameter int HYST         = 2,
  parameter int SUPPLY_LIMIT = 97,
  parameter int CPU_LIMIT    = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] supplyTemp,
  input  logic              supplyValid,
  input  logic [TEMP_W-1:0] cpuTemp,
  input  logic              cpuValid,
  output logic [1:0]        fanSpeed,
  output logic              auxFanOn,
  output logic              nearShutdownWarn,
  output logic              shutdownReq,
  output logic              supplyFault,
  output logic              cpuFault
);

  tempFlags_t   flags;
  ctrlStrobes_t strobes;
  fanSpeed_e    curSpeed;

  thermal_fan_control u_ctrl (
    .supplyValid (supplyValid),
    .cpuValid    (cpuValid),
    .flags       (flags),
    .curSpeed    (curSpeed),
    .strobes     (strobes)
  );

  thermal_fan_datapath #(
    .TEMP_W       (TEMP_W),
    .MED_UP       (MED_UP),
    .HIGH_UP      (HIGH_UP),
    .HYST         (HYST),
    .SUPPLY_LIMIT (SUPPLY_LIMIT),
    .CPU_LIMIT    (CPU_LIMIT)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .supplyTemp     (supplyTemp),
    .cpuTemp        (cpuTemp),
    .strobes        (strobes),
    .flags          (flags),
    .curSpeed       (curSpeed),
    .warnOut        (nearShutdownWarn),
    .shutOut        (shutdownReq),
    .supplyFaultOut (supplyFault),
    .cpuFaultOut    (cpuFault)
  );

  assign fanSpeed = curSpeed;
  assign auxFanOn = 1'b1;

endmodule

// File: rtl/thermal_fan_ctrl_checker.sv
module thermal_fan_ctrl_checker #(
  parameter int TEMP_W       = 8,
  parameter int HIGH_UP      = 51,
  parameter int HYST         = 2,
  parameter int SUPPLY_LIMIT = 97,
  parameter int CPU_LIMIT    = 100
) (
  input logic              clk,
  input logic              rstN,
  input logic [TEMP_W-1:0] supplyTemp,
  input logic              supplyValid,
  input logic [TEMP_W-1:0] cpuTemp,
  input logic              cpuValid,
  input logic [1:0]        fanSpeed,
  input logic              nearShutdownWarn,
  input logic              shutdownReq,
  input logic              supplyFault,
  input logic              cpuFault
);

  localparam int HIGH_DOWN = HIGH_UP - HYST;

  assert_speed_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    fanSpeed != 2'd3);

  assert_warn_at_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    nearShutdownWarn == (fanSpeed == 2'd2));

  assert_high_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fanSpeed == 2'd2 && supplyValid && int'($signed(supplyTemp)) >= HIGH_DOWN)
      |=> fanSpeed == 2'd2);

  assert_no_valid_no_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    !supplyValid |=> $stable(fanSpeed));

  assert_supply_trip_R7: assert property (@(posedge clk) disable iff (!rstN)
    (supplyValid && int'($signed(supplyTemp)) > SUPPLY_LIMIT) |=> (supplyFault && shutdownReq));

  assert_cpu_trip_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && int'($signed(cpuTemp)) > CPU_LIMIT) |=> (cpuFault && shutdownReq));

  assert_cpu_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuFault) |-> $past(cpuValid && int'($signed(cpuTemp)) > CPU_LIMIT));

  assert_shutdown_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |=> shutdownReq);

  assert_cause_matches_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    (supplyFault || cpuFault) == shutdownReq);

endmodule

bind thermal_fan_ctrl thermal_fan_ctrl_checker #(
  .TEMP_W       (TEMP_W),
  .HIGH_UP      (HIGH_UP),
  .HYST         (HYST),
  .SUPPLY_LIMIT (SUPPLY_LIMIT),
  .CPU_LIMIT    (CPU_LIMIT)
) u_checker (
  .clk              (clk),
  .rstN             (rstN),
  .supplyTemp       (supplyTemp),
  .supplyValid      (supplyValid),
  .cpuTemp          (cpuTemp),
  .cpuValid         (cpuValid),
  .fanSpeed         (fanSpeed),
  .nearShutdownWarn (nearShutdownWarn),
  .shutdownReq      (shutdownReq),
  .supplyFault      (supplyFault),
  .cpuFault         (cpuFault)
);

// File: tb/thermal_fan_ctrl_test.sv
module thermal_fan_ctrl_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] supplyTemp = '0;
  logic       supplyValid = 1'b0;
  logic [7:0] cpuTemp = '0;
  logic       cpuValid = 1'b0;
  logic [1:0] fanSpeed;
  logic       auxFanOn;
  logic       nearShutdownWarn;
  logic       shutdownReq;
  logic       supplyFault;
  logic       cpuFault;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  thermal_fan_ctrl uut (
    .clk              (clk),
    .rstN             (rstN),
    .supplyTemp       (supplyTemp),
    .supplyValid      (supplyValid),
    .cpuTemp          (cpuTemp),
    .cpuValid         (cpuValid),
    .fanSpeed         (fanSpeed),
    .auxFanOn         (auxFanOn),
    .nearShutdownWarn (nearShutdownWarn),
    .shutdownReq      (shutdownReq),
    .supplyFault      (supplyFault),
    .cpuFault         (cpuFault)
  );

  typedef struct packed {
    logic       sv;
    logic [7:0] st;
    logic       cv;
    logic [7:0] ct;
    logic [1:0] es;
  } vec_t;

  // Speed walk from reset; no vector trips a limit.
  localparam int NVEC = 18;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 8'd25,  1'b0, 8'd0,   2'd0},  // R2 cool
    '{1'b1, 8'd39,  1'b0, 8'd0,   2'd0},  // R2 boundary stays low
    '{1'b1, 8'd40,  1'b0, 8'd0,   2'd1},  // R2 step to medium
    '{1'b1, 8'd38,  1'b0, 8'd0,   2'd1},  // R4 hold medium
    '{1'b1, 8'd37,  1'b0, 8'd0,   2'd1},  // R4 hold at step-down point
    '{1'b1, 8'd36,  1'b0, 8'd0,   2'd0},  // R4 drop to low
    '{1'b1, 8'd52,  1'b0, 8'd0,   2'd2},  // R3 jump low to high
    '{1'b1, 8'd49,  1'b0, 8'd0,   2'd2},  // R4 hold high
    '{1'b1, 8'd48,  1'b0, 8'd0,   2'd1},  // R4 high to medium
    '{1'b0, 8'd10,  1'b0, 8'd0,   2'd1},  // R6 invalid ignored
    '{1'b0, 8'd10,  1'b1, 8'd90,  2'd1},  // R5 processor reading only
    '{1'b1, 8'd51,  1'b0, 8'd0,   2'd1},  // R3 boundary stays medium
    '{1'b1, 8'd52,  1'b0, 8'd0,   2'd2},  // R3 medium to high
    '{1'b0, 8'd0,   1'b1, 8'd20,  2'd2},  // R5 cool processor no step down
    '{1'b1, 8'd30,  1'b0, 8'd0,   2'd0},  // R4 high to low
    '{1'b1, 8'h9C,  1'b0, 8'd0,   2'd0},  // R10 -100 is cold
    '{1'b0, 8'd0,   1'b1, 8'd100, 2'd0},  // R8 boundary no trip
    '{1'b1, 8'd97,  1'b0, 8'd0,   2'd2}   // R7 boundary no trip, R3 high
  };

  task automatic check(input string req, input logic [1:0] es, input logic ew,
                       input logic esh, input logic esf, input logic ecf);
    testsRun++;
    if (fanSpeed !== es || nearShutdownWarn !== ew || shutdownReq !== esh ||
        supplyFault !== esf || cpuFault !== ecf || auxFanOn !== 1'b1) begin
      testsFailed++;
      $display("FAIL %s: got spd=%0d warn=%0b shut=%0b sf=%0b cf=%0b aux=%0b exp spd=%0d warn=%0b shut=%0b sf=%0b cf=%0b aux=1",
               req, fanSpeed, nearShutdownWarn, shutdownReq, supplyFault, cpuFault, auxFanOn,
               es, ew, esh, esf, ecf);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge (R11)
  task automatic apply(input logic sv, input logic [7:0] st, input logic cv, input logic [7:0] ct);
    @(negedge clk);
    supplyValid = sv; supplyTemp = st; cpuValid = cv; cpuTemp = ct;
    @(negedge clk);
    supplyValid = 1'b0; cpuValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; supplyValid = 1'b0; cpuValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    check("R1 reset state", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i].sv, VEC[i].st, VEC[i].cv, VEC[i].ct);
      check($sformatf("vector %0d (R2-R6 speed walk, R11 timing)", i), VEC[i].es,
            VEC[i].es == 2'd2, 1'b0, 1'b0, 1'b0);
    end

    // R7 + R3 on the same edge
    doReset();
    apply(1'b1, 8'd98, 1'b0, 8'd0);
    check("R7 supply trip with jump to high", 2'd2, 1'b1, 1'b1, 1'b1, 1'b0);
    apply(1'b1, 8'd20, 1'b1, 8'd20);
    check("R9 latched after cooling", 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    doReset();
    check("R9 reset clears latches", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R8 processor trip
    apply(1'b0, 8'd0, 1'b1, 8'd101);
    check("R8 processor trip", 2'd0, 1'b0, 1'b1, 1'b0, 1'b1);

    // R9 both limits in one cycle
    doReset();
    apply(1'b1, 8'd100, 1'b1, 8'd120);
    check("R9 both causes same cycle", 2'd2, 1'b1, 1'b1, 1'b1, 1'b1);

    // R6 critical readings without strobes
    doReset();
    apply(1'b0, 8'd120, 1'b0, 8'd120);
    check("R6 unstrobed critical readings", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R10 most negative processor value
    apply(1'b0, 8'd0, 1'b1, 8'h80);
    check("R10 processor -128 no trip", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule